// File: doc/BRIEF.md
# Low-Power Operating Mode Controller

This block sequences a low-energy radio system-on-chip through six power modes: Reset, Standby, Sleep, Active, Receive and Transmit. Each mode turns on a fixed set of resource enables: the digital regulator, the serial host port, the low-speed oscillator, the high-speed oscillator, the processor core, the RF synthesizer, the receive chain, the transmit chain and the power of the second RAM bank. The analog parts these enables control are outside the block.

Mode changes come from a chip-level reset input, a wake-up timer expiry, a host wake request over the serial port and software requests for sleep, standby, receive and transmit. Every accepted change starts a down-counter that models the settling time of the resources involved. The reload value is a parameter in clock cycles, and it depends on the source mode, on the low-speed clock source in use and on whether the radio must retune. The controller reports the current mode and a ready flag. While a change is still settling it ignores all requests. A request with no legal path from the current mode produces a one-cycle error pulse.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, `mode_o` reads Reset (code 0) and every enable output and `ready_o` are low.
- R2: When `ext_reset_i` is high at a clock edge, the next cycle shows Reset from any mode, including during a transition. The first edge that sees it low moves to Active (code 3). Ready then stays low for P_RST_NONE, P_RST_RING or P_RST_XTAL cycles, chosen by `lsclk_sel_i` = 0, 1, or 2/3.
- R3: Mode codes are Standby=1, Sleep=2, Active=3, RX=4, TX=5. Enables are on as follows: Standby gives regulator and port; Sleep adds the low-speed oscillator; Active adds the high-speed oscillator and core; RX adds synthesizer and receive chain; TX adds synthesizer and transmit chain. Every enable not listed is off.
- R4: In Sleep, either `timer_expire_i` or `spi_wake_i` moves to Active with a settling time of P_SLEEP_WAKE cycles.
- R5: In Standby, only `spi_wake_i` moves to Active, with P_STBY_NONE, P_STBY_RING or P_STBY_XTAL cycles chosen by `lsclk_sel_i` as in R2. In Standby, `timer_expire_i` counts as an illegal request.
- R6: From Active, `req_rx_i` enters RX in P_RX_NOCHG cycles, or P_RX_CHG when `chan_chg_i` is high. `req_tx_i` enters TX in P_TX_NOCHG or P_TX_CHG cycles.
- R7: `req_tx_i` in RX and `req_rx_i` in TX switch direction in P_TURN cycles.
- R8: From Active, RX or TX, `req_sleep_i` enters Sleep and `req_standby_i` enters Standby, each in P_DOWN cycles.
- R9: After an accepted change, the new mode shows in the next cycle and `ready_o` is low for exactly the settling count. Requests and wake events that arrive while ready is low are ignored, with no error.
- R10: While ready, a software request that is not legal in the current mode (any request in Sleep or Standby, a timer expiry in Standby, and RX in RX or TX in TX) pulses `err_o` for one cycle and leaves the mode unchanged. Wake events in Active, RX or TX are ignored silently.
- R11: `ram2_en_o` is low in Reset, and also low in Sleep when `ret_off_i` is high. It is high in every other mode.
- R12: When several inputs arrive together, the priority is sleep, then standby, then RX, then TX. In Sleep or Standby, a valid wake event takes priority over software requests and raises no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the controller |
| ext_reset_i | input | 1 | Chip reset input; holds the Reset mode |
| lsclk_sel_i | input | 2 | Low-speed clock source: 0 none, 1 ring, 2/3 crystal |
| ret_off_i | input | 1 | Power down the second RAM bank in Sleep |
| chan_chg_i | input | 1 | Radio entry from Active needs a channel change |
| timer_expire_i | input | 1 | Wake-up timer expired |
| spi_wake_i | input | 1 | Host wake request over the serial port |
| req_sleep_i | input | 1 | Software request: Sleep |
| req_standby_i | input | 1 | Software request: Standby |
| req_rx_i | input | 1 | Software request: receive |
| req_tx_i | input | 1 | Software request: transmit |
| mode_o | output | 3 | Current mode code |
| ready_o | output | 1 | Settling done; requests accepted |
| err_o | output | 1 | One-cycle pulse on an illegal request |
| reg_en_o | output | 1 | Digital regulator enable |
| spi_en_o | output | 1 | Serial host port enable |
| lsosc_en_o | output | 1 | Low-speed oscillator enable |
| hsosc_en_o | output | 1 | High-speed oscillator enable |
| core_en_o | output | 1 | Processor core enable |
| synth_en_o | output | 1 | RF synthesizer enable |
| rx_en_o | output | 1 | Receive chain enable |
| tx_en_o | output | 1 | Transmit chain enable |
| ram2_en_o | output | 1 | Second RAM bank power enable |

## Verification
The assertions check several properties on every cycle. Reset mode keeps every enable and ready low. The chip reset input wins on the next cycle. Receive and transmit chains are never both on, and Standby never runs an oscillator. The mode holds while ready is low, and errors appear only while ready. Standby is left only for Active or Reset, and the RAM bank is off in Sleep when retention is off. Other properties depend on the stimulus, so only the bench scenarios can show them. These are the exact settling count for each path, clock source and channel-change setting, the legality of every request in every mode, the priority of simultaneous requests, and that requests are ignored while settling.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

    typedef enum logic [2:0] {
        M_RESET   = 3'd0,
        M_STANDBY = 3'd1,
        M_SLEEP   = 3'd2,
        M_ACTIVE  = 3'd3,
        M_RX      = 3'd4,
        M_TX      = 3'd5
    } pmc_mode_e;

    typedef struct packed {
        logic regl;
        logic spi;
        logic lsosc;
        logic hsosc;
        logic core;
        logic synth;
        logic rxc;
        logic txc;
    } pmc_en_s;

    // Fixed resource map of each mode.
    function automatic pmc_en_s mode_enables(input pmc_mode_e m);
        pmc_en_s e;
        e = '0;
        case (m)
            M_STANDBY: begin e.regl = 1'b1; e.spi = 1'b1; end
            M_SLEEP:   begin e.regl = 1'b1; e.spi = 1'b1; e.lsosc = 1'b1; end
            M_ACTIVE, M_RX, M_TX: begin
                e.regl  = 1'b1; e.spi  = 1'b1; e.lsosc = 1'b1;
                e.hsosc = 1'b1; e.core = 1'b1;
                e.synth = (m != M_ACTIVE);
                e.rxc   = (m == M_RX);
                e.txc   = (m == M_TX);
            end
            default: e = '0;
        endcase
        return e;
    endfunction

    // Low-speed clock source classes.
    typedef enum logic [1:0] {LS_NONE = 2'd0, LS_RING = 2'd1, LS_XTAL = 2'd2} pmc_ls_e;

    function automatic pmc_ls_e ls_class(input logic [1:0] sel);
        if (sel[1])       return LS_XTAL;
        else if (sel[0])  return LS_RING;
        else              return LS_NONE;
    endfunction

endpackage

// File: rtl/pmc_lat_sel.sv
module pmc_lat_sel
    import pmc_pkg::*;
#(
    parameter int unsigned CNT_W        = 22,
    parameter int unsigned P_RST_NONE   = 1,
    parameter int unsigned P_RST_RING   = 1,
    parameter int unsigned P_RST_XTAL   = 1,
    parameter int unsigned P_STBY_NONE  = 1,
    parameter int unsigned P_STBY_RING  = 1,
    parameter int unsigned P_STBY_XTAL  = 1,
    parameter int unsigned P_SLEEP_WAKE = 1,
    parameter int unsigned P_RX_NOCHG   = 1,
    parameter int unsigned P_RX_CHG     = 1,
    parameter int unsigned P_TX_NOCHG   = 1,
    parameter int unsigned P_TX_CHG     = 1,
    parameter int unsigned P_TURN       = 1,
    parameter int unsigned P_DOWN       = 1
) (
    input  pmc_mode_e        cur_mode,
    input  pmc_mode_e        nxt_mode,
    input  logic [1:0]       lsclk_sel,
    input  logic             chan_chg,
    output logic [CNT_W-1:0] lat
);
    localparam logic [CNT_W-1:0] L_RST_NONE  = CNT_W'(P_RST_NONE);
    localparam logic [CNT_W-1:0] L_RST_RING  = CNT_W'(P_RST_RING);
    localparam logic [CNT_W-1:0] L_RST_XTAL  = CNT_W'(P_RST_XTAL);
    localparam logic [CNT_W-1:0] L_STBY_NONE = CNT_W'(P_STBY_NONE);
    localparam logic [CNT_W-1:0] L_STBY_RING = CNT_W'(P_STBY_RING);
    localparam logic [CNT_W-1:0] L_STBY_XTAL = CNT_W'(P_STBY_XTAL);
    localparam logic [CNT_W-1:0] L_SLEEP     = CNT_W'(P_SLEEP_WAKE);
    localparam logic [CNT_W-1:0] L_RX_NC     = CNT_W'(P_RX_NOCHG);
    localparam logic [CNT_W-1:0] L_RX_CH     = CNT_W'(P_RX_CHG);
    localparam logic [CNT_W-1:0] L_TX_NC     = CNT_W'(P_TX_NOCHG);
    localparam logic [CNT_W-1:0] L_TX_CH     = CNT_W'(P_TX_CHG);
    localparam logic [CNT_W-1:0] L_TURN      = CNT_W'(P_TURN);
    localparam logic [CNT_W-1:0] L_DOWN      = CNT_W'(P_DOWN);

    pmc_ls_e ls;
    assign ls = ls_class(lsclk_sel);

    always_comb begin
        lat = L_DOWN;
        case (nxt_mode)
            M_ACTIVE: begin
                if (cur_mode == M_SLEEP) begin
                    lat = L_SLEEP;
                end else if (cur_mode == M_STANDBY) begin
                    case (ls)
                        LS_RING: lat = L_STBY_RING;
                        LS_XTAL: lat = L_STBY_XTAL;
                        default: lat = L_STBY_NONE;
                    endcase
                end else begin
                    case (ls)
                        LS_RING: lat = L_RST_RING;
                        LS_XTAL: lat = L_RST_XTAL;
                        default: lat = L_RST_NONE;
                    endcase
                end
            end
            M_RX: begin
                if (cur_mode == M_TX) lat = L_TURN;
                else                  lat = chan_chg ? L_RX_CH : L_RX_NC;
            end
            M_TX: begin
                if (cur_mode == M_RX) lat = L_TURN;
                else                  lat = chan_chg ? L_TX_CH : L_TX_NC;
            end
            default: lat = L_DOWN;
        endcase
    end
endmodule

// File: rtl/pmc_down_cnt.sv
module pmc_down_cnt #(
    parameter int unsigned CNT_W = 22
) (
    input  logic             clk,
    input  logic             clr,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             zero
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (clr)               cnt_q <= '0;
        else if (load)         cnt_q <= load_val;
        else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/pmc_en_map.sv
module pmc_en_map
    import pmc_pkg::*;
(
    input  pmc_mode_e mode,
    input  logic      ret_off,
    output pmc_en_s   en,
    output logic      ram2_en
);
    assign en      = mode_enables(mode);
    assign ram2_en = (mode != M_RESET) && !((mode == M_SLEEP) && ret_off);
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
    import pmc_pkg::*;
#(
    parameter int unsigned CNT_W        = 22,
    parameter int unsigned P_RST_NONE   = 48000,
    parameter int unsigned P_RST_RING   = 224000,
    parameter int unsigned P_RST_XTAL   = 3008000,
    parameter int unsigned P_STBY_NONE  = 13440,
    parameter int unsigned P_STBY_RING  = 198400,
    parameter int unsigned P_STBY_XTAL  = 2976000,
    parameter int unsigned P_SLEEP_WAKE = 13440,
    parameter int unsigned P_RX_NOCHG   = 1952,
    parameter int unsigned P_RX_CHG     = 4000,
    parameter int unsigned P_TX_NOCHG   = 2144,
    parameter int unsigned P_TX_CHG     = 4192,
    parameter int unsigned P_TURN       = 4800,
    parameter int unsigned P_DOWN       = 32
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       ext_reset_i,
    input  logic [1:0] lsclk_sel_i,
    input  logic       ret_off_i,
    input  logic       chan_chg_i,
    input  logic       timer_expire_i,
    input  logic       spi_wake_i,
    input  logic       req_sleep_i,
    input  logic       req_standby_i,
    input  logic       req_rx_i,
    input  logic       req_tx_i,
    output logic [2:0] mode_o,
    output logic       ready_o,
    output logic       err_o,
    output logic       reg_en_o,
    output logic       spi_en_o,
    output logic       lsosc_en_o,
    output logic       hsosc_en_o,
    output logic       core_en_o,
    output logic       synth_en_o,
    output logic       rx_en_o,
    output logic       tx_en_o,
    output logic       ram2_en_o
);
    pmc_mode_e        mode_q, mode_d;
    logic             err_q, err_d;
    logic             load;
    logic             cnt_zero;
    logic [CNT_W-1:0] lat;
    logic             any_sw;
    pmc_en_s          en;

    assign any_sw = req_sleep_i | req_standby_i | req_rx_i | req_tx_i;

    // Next-mode decision (R2, R4-R10, R12).
    always_comb begin
        mode_d = mode_q;
        load   = 1'b0;
        err_d  = 1'b0;
        if (ext_reset_i) begin
            mode_d = M_RESET;
        end else if (mode_q == M_RESET) begin
            mode_d = M_ACTIVE;
            load   = 1'b1;
        end else if (cnt_zero) begin
            case (mode_q)
                M_SLEEP: begin
                    if (timer_expire_i || spi_wake_i) begin
                        mode_d = M_ACTIVE; load = 1'b1;
                    end else if (any_sw) begin
                        err_d = 1'b1;
                    end
                end
                M_STANDBY: begin
                    if (spi_wake_i) begin
                        mode_d = M_ACTIVE; load = 1'b1;
                    end else if (timer_expire_i || any_sw) begin
                        err_d = 1'b1;
                    end
                end
                M_ACTIVE: begin
                    load = any_sw;
                    if (req_sleep_i)        mode_d = M_SLEEP;
                    else if (req_standby_i) mode_d = M_STANDBY;
                    else if (req_rx_i)      mode_d = M_RX;
                    else if (req_tx_i)      mode_d = M_TX;
                end
                M_RX, M_TX: begin
                    if (req_sleep_i) begin
                        mode_d = M_SLEEP; load = 1'b1;
                    end else if (req_standby_i) begin
                        mode_d = M_STANDBY; load = 1'b1;
                    end else if (req_rx_i) begin
                        if (mode_q == M_TX) begin mode_d = M_RX; load = 1'b1; end
                        else                  err_d = 1'b1;
                    end else if (req_tx_i) begin
                        if (mode_q == M_RX) begin mode_d = M_TX; load = 1'b1; end
                        else                  err_d = 1'b1;
                    end
                end
                default: mode_d = M_RESET;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= M_RESET;
            err_q  <= 1'b0;
        end else begin
            mode_q <= mode_d;
            err_q  <= err_d;
        end
    end

    pmc_lat_sel #(
        .CNT_W(CNT_W),
        .P_RST_NONE(P_RST_NONE), .P_RST_RING(P_RST_RING), .P_RST_XTAL(P_RST_XTAL),
        .P_STBY_NONE(P_STBY_NONE), .P_STBY_RING(P_STBY_RING), .P_STBY_XTAL(P_STBY_XTAL),
        .P_SLEEP_WAKE(P_SLEEP_WAKE),
        .P_RX_NOCHG(P_RX_NOCHG), .P_RX_CHG(P_RX_CHG),
        .P_TX_NOCHG(P_TX_NOCHG), .P_TX_CHG(P_TX_CHG),
        .P_TURN(P_TURN), .P_DOWN(P_DOWN)
    ) u_lat (
        .cur_mode (mode_q),
        .nxt_mode (mode_d),
        .lsclk_sel(lsclk_sel_i),
        .chan_chg (chan_chg_i),
        .lat      (lat)
    );

    pmc_down_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .clr     (rst | ext_reset_i),
        .load    (load),
        .load_val(lat),
        .zero    (cnt_zero)
    );

    pmc_en_map u_map (
        .mode   (mode_q),
        .ret_off(ret_off_i),
        .en     (en),
        .ram2_en(ram2_en_o)
    );

    assign mode_o     = mode_q;
    assign ready_o    = cnt_zero && (mode_q != M_RESET);
    assign err_o      = err_q;
    assign reg_en_o   = en.regl;
    assign spi_en_o   = en.spi;
    assign lsosc_en_o = en.lsosc;
    assign hsosc_en_o = en.hsosc;
    assign core_en_o  = en.core;
    assign synth_en_o = en.synth;
    assign rx_en_o    = en.rxc;
    assign tx_en_o    = en.txc;
endmodule

// File: rtl/pwr_mode_ctrl_chk.sv
module pwr_mode_ctrl_chk
    import pmc_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       ext_reset_i,
    input logic       ret_off_i,
    input logic [2:0] mode_o,
    input logic       ready_o,
    input logic       err_o,
    input logic       reg_en_o,
    input logic       spi_en_o,
    input logic       lsosc_en_o,
    input logic       hsosc_en_o,
    input logic       core_en_o,
    input logic       synth_en_o,
    input logic       rx_en_o,
    input logic       tx_en_o,
    input logic       ram2_en_o
);
    p_reset_dark_r1: assert property (@(posedge clk) disable iff (rst)
        (mode_o == M_RESET) |-> !(reg_en_o | spi_en_o | lsosc_en_o | hsosc_en_o |
                                  core_en_o | synth_en_o | rx_en_o | tx_en_o |
                                  ram2_en_o | ready_o));

    p_ext_reset_wins_r2: assert property (@(posedge clk) disable iff (rst)
        ext_reset_i |=> (mode_o == M_RESET));

    p_chains_exclusive_r3: assert property (@(posedge clk) disable iff (rst)
        !(rx_en_o && tx_en_o));

    p_standby_no_osc_r3: assert property (@(posedge clk) disable iff (rst)
        (mode_o == M_STANDBY) |-> (!lsosc_en_o && !hsosc_en_o && !core_en_o && spi_en_o));

    p_standby_exit_r5: assert property (@(posedge clk) disable iff (rst)
        ($past(mode_o) == M_STANDBY && mode_o != M_STANDBY) |->
            (mode_o == M_ACTIVE || mode_o == M_RESET));

    p_hold_while_busy_r9: assert property (@(posedge clk) disable iff (rst)
        (!ready_o && mode_o != M_RESET && !ext_reset_i) |=> $stable(mode_o));

    p_err_when_ready_r10: assert property (@(posedge clk) disable iff (rst)
        err_o |-> $past(ready_o));

    p_ram2_retention_r11: assert property (@(posedge clk) disable iff (rst)
        (mode_o == M_SLEEP && ret_off_i) |-> !ram2_en_o);
endmodule

bind pwr_mode_ctrl pwr_mode_ctrl_chk u_chk (
    .clk(clk), .rst(rst), .ext_reset_i(ext_reset_i), .ret_off_i(ret_off_i),
    .mode_o(mode_o), .ready_o(ready_o), .err_o(err_o),
    .reg_en_o(reg_en_o), .spi_en_o(spi_en_o), .lsosc_en_o(lsosc_en_o),
    .hsosc_en_o(hsosc_en_o), .core_en_o(core_en_o), .synth_en_o(synth_en_o),
    .rx_en_o(rx_en_o), .tx_en_o(tx_en_o), .ram2_en_o(ram2_en_o)
);

// File: tb/pwr_mode_ctrl_test.sv
module pwr_mode_ctrl_test;
    localparam int L_RN = 10, L_RR = 12, L_RX = 14;
    localparam int L_SN = 5,  L_SR = 6,  L_SX = 7;
    localparam int L_SW = 4,  L_RXN = 3, L_RXC = 6, L_TXN = 4, L_TXC = 7;
    localparam int L_TURN = 8, L_DOWN = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ext_reset = 1'b1;
    logic [1:0] lsel = 2'd0;
    logic ret_off = 1'b0, chg = 1'b0, tmr = 1'b0, spw = 1'b0;
    logic rq_sl = 1'b0, rq_sb = 1'b0, rq_rx = 1'b0, rq_tx = 1'b0;
    logic [2:0] mode;
    logic ready, err, e_reg, e_spi, e_ls, e_hs, e_core, e_syn, e_rx, e_tx, e_ram2;

    int compared = 0;
    int mismatched = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    pwr_mode_ctrl #(
        .CNT_W(8),
        .P_RST_NONE(L_RN), .P_RST_RING(L_RR), .P_RST_XTAL(L_RX),
        .P_STBY_NONE(L_SN), .P_STBY_RING(L_SR), .P_STBY_XTAL(L_SX),
        .P_SLEEP_WAKE(L_SW), .P_RX_NOCHG(L_RXN), .P_RX_CHG(L_RXC),
        .P_TX_NOCHG(L_TXN), .P_TX_CHG(L_TXC), .P_TURN(L_TURN), .P_DOWN(L_DOWN)
    ) uut (
        .clk(clk), .rst(rst), .ext_reset_i(ext_reset), .lsclk_sel_i(lsel),
        .ret_off_i(ret_off), .chan_chg_i(chg), .timer_expire_i(tmr),
        .spi_wake_i(spw), .req_sleep_i(rq_sl), .req_standby_i(rq_sb),
        .req_rx_i(rq_rx), .req_tx_i(rq_tx), .mode_o(mode), .ready_o(ready),
        .err_o(err), .reg_en_o(e_reg), .spi_en_o(e_spi), .lsosc_en_o(e_ls),
        .hsosc_en_o(e_hs), .core_en_o(e_core), .synth_en_o(e_syn),
        .rx_en_o(e_rx), .tx_en_o(e_tx), .ram2_en_o(e_ram2)
    );

    task automatic check(input string req, input int act, input int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    // Expected enables {reg,spi,ls,hs,core,syn,rx,tx,ram2} per R3 and R11.
    function automatic int exp_en(input int m, input bit ro);
        int v;
        case (m)
            1: v = 9'b110000001;
            2: v = ro ? 9'b111000000 : 9'b111000001;
            3: v = 9'b111110001;
            4: v = 9'b111111101;
            5: v = 9'b111111011;
            default: v = 0;
        endcase
        return v;
    endfunction

    function automatic int act_en();
        return {e_reg, e_spi, e_ls, e_hs, e_core, e_syn, e_rx, e_tx, e_ram2};
    endfunction

    function automatic int lat_rst(input int s);
        return (s >= 2) ? L_RX : (s == 1) ? L_RR : L_RN;
    endfunction

    function automatic int lat_stby(input int s);
        return (s >= 2) ? L_SX : (s == 1) ? L_SR : L_SN;
    endfunction

    // Stimulus codes: 0 sleep, 1 standby, 2 rx, 3 tx, 4 timer, 5 spi wake.
    task automatic exp_step(input int m, input int s, input int sel, input bit c,
                            output int nm, output bit e, output int lat);
        nm = m; e = 1'b0; lat = 0;
        case (m)
            2: if (s >= 4) begin nm = 3; lat = L_SW; end else e = 1'b1;
            1: if (s == 5) begin nm = 3; lat = lat_stby(sel); end else e = 1'b1;
            3: case (s)
                   0: begin nm = 2; lat = L_DOWN; end
                   1: begin nm = 1; lat = L_DOWN; end
                   2: begin nm = 4; lat = c ? L_RXC : L_RXN; end
                   3: begin nm = 5; lat = c ? L_TXC : L_TXN; end
                   default: ;
               endcase
            default: case (s)
                   0: begin nm = 2; lat = L_DOWN; end
                   1: begin nm = 1; lat = L_DOWN; end
                   2: if (m == 5) begin nm = 4; lat = L_TURN; end else e = 1'b1;
                   3: if (m == 4) begin nm = 5; lat = L_TURN; end else e = 1'b1;
                   default: ;
               endcase
        endcase
    endtask

    task automatic drive(input int s, input bit v);
        case (s)
            0: rq_sl = v;
            1: rq_sb = v;
            2: rq_rx = v;
            3: rq_tx = v;
            4: tmr = v;
            default: spw = v;
        endcase
    endtask

    // Counts samples with ready low, starting at the current negedge.
    task automatic measure(output int n);
        n = 0;
        while (!ready && n < 100) begin
            n++;
            @(negedge clk);
        end
    endtask

    // Hold stimulus across one edge; return at the negedge after it.
    task automatic apply(input int s);
        @(negedge clk);
        drive(s, 1'b1);
        @(negedge clk);
        drive(s, 1'b0);
    endtask

    task automatic goto_mode(input int m);
        int n;
        @(negedge clk);
        ext_reset = 1'b1; lsel = 2'd0; chg = 1'b0;
        @(negedge clk);
        ext_reset = 1'b0;
        @(negedge clk);
        measure(n);
        case (m)
            1: apply(1);
            2: apply(0);
            4: apply(2);
            5: apply(3);
            default: ;
        endcase
        measure(n);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            mismatched++;
            $display("FAIL R9: watchdog expired, actual 1 expected 0");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        int n, nm, lat;
        bit e;

        // R1: reset state.
        repeat (3) @(negedge clk);
        check("R1 mode in rst", mode, 0);
        check("R1 enables in rst", act_en(), 0);
        check("R1 ready in rst", ready, 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 mode after rst", mode, 0);
        check("R1 ready after rst", ready, 0);
        check("R1 enables after rst", act_en(), 0);

        // R2: release latency for each low-speed clock selection.
        for (int sel = 0; sel < 4; sel++) begin
            @(negedge clk);
            ext_reset = 1'b1; lsel = 2'(sel);
            @(negedge clk);
            check("R2 held in reset", mode, 0);
            ext_reset = 1'b0;
            @(negedge clk);
            check("R2 active after release", mode, 3);
            measure(n);
            check("R2 release latency", n, lat_rst(sel));
            check("R3 active enables", act_en(), exp_en(3, 1'b0));
        end

        // Legality, target and latency sweep over modes, stimuli, clocks, retune.
        for (int m = 1; m <= 5; m++) begin
            for (int s = 0; s < 6; s++) begin
                for (int sel = 0; sel < 4; sel++) begin
                    for (int c = 0; c < 2; c++) begin
                        goto_mode(m);
                        check("R3 mode enables", act_en(), exp_en(m, 1'b0));
                        lsel = 2'(sel); chg = c[0];
                        exp_step(m, s, sel, c[0], nm, e, lat);
                        apply(s);
                        check("R10 err pulse", err, int'(e));
                        check("R4 R5 R6 R7 R8 next mode", mode, nm);
                        measure(n);
                        check("R9 settle count", n, lat);
                        @(negedge clk);
                        check("R10 err one cycle", err, 0);
                        check("R3 enables after step", act_en(), exp_en(nm, 1'b0));
                    end
                end
            end
        end

        // R11: retention control in Sleep.
        goto_mode(2);
        ret_off = 1'b1;
        @(negedge clk);
        check("R11 ram2 off in sleep", e_ram2, 0);
        ret_off = 1'b0;
        @(negedge clk);
        check("R11 ram2 on in sleep", e_ram2, 1);
        ret_off = 1'b1;
        apply(4);
        check("R11 ram2 on in active", e_ram2, 1);
        ret_off = 1'b0;
        measure(n);

        // R9: requests while settling are ignored.
        goto_mode(3);
        apply(2);
        check("R9 entered rx", mode, 4);
        rq_tx = 1'b1; rq_sl = 1'b1;
        @(negedge clk);
        rq_tx = 1'b0; rq_sl = 1'b0;
        check("R9 busy request ignored", mode, 4);
        check("R9 busy no err", err, 0);
        measure(n);
        check("R9 remaining count", n, L_RXN - 1);
        check("R9 mode kept", mode, 4);

        // R2: chip reset during a transition.
        apply(3);
        @(negedge clk);
        ext_reset = 1'b1;
        @(negedge clk);
        check("R2 reset mid-transition", mode, 0);
        check("R1 enables in reset mode", act_en(), 0);
        ext_reset = 1'b0;
        @(negedge clk);
        measure(n);

        // R12: simultaneous requests.
        goto_mode(3);
        @(negedge clk);
        rq_rx = 1'b1; rq_sl = 1'b1; rq_tx = 1'b1;
        @(negedge clk);
        rq_rx = 1'b0; rq_sl = 1'b0; rq_tx = 1'b0;
        check("R12 sleep beats rx", mode, 2);
        measure(n);
        @(negedge clk);
        spw = 1'b1; rq_tx = 1'b1;
        @(negedge clk);
        spw = 1'b0; rq_tx = 1'b0;
        check("R12 wake beats request", mode, 3);
        check("R12 no err", err, 0);
        measure(n);
        @(negedge clk);
        rq_sb = 1'b1; rq_rx = 1'b1;
        @(negedge clk);
        rq_sb = 1'b0; rq_rx = 1'b0;
        check("R12 standby beats rx", mode, 1);
        measure(n);
        @(negedge clk);
        tmr = 1'b1; spw = 1'b1;
        @(negedge clk);
        tmr = 1'b0; spw = 1'b0;
        check("R12 spi wake in standby", mode, 3);
        check("R12 standby wake no err", err, 0);
        measure(n);
        @(negedge clk);
        rq_rx = 1'b1; rq_tx = 1'b1;
        @(negedge clk);
        rq_rx = 1'b0; rq_tx = 1'b0;
        check("R12 rx beats tx", mode, 4);
        measure(n);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule